// File: doc/BRIEF.md
# H-Bridge Fault and Power-State Supervisor

This block decides, cycle by cycle, whether each H-bridge of a dual-bridge motor driver may conduct. It watches the per-switch current-limit flags, a die overtemperature flag and a supply undervoltage flag, together with two active-low control requests: one for reset and one for sleep. From these it produces a disable line for every bridge, a clear line for the rest of the driver's logic, an enable for the internal clocks and charge pump, an active-low fault indication and a ready flag.

The protections recover in different ways. An overcurrent that persists past a programmable number of cycles shuts its own bridge down. That shutdown stays latched until a reset request or a supply collapse. An overtemperature shuts every bridge down for as long as the flag is present and releases them as soon as it drops. An undervoltage clears all state. After the supply, reset and sleep requests all become good, a programmable wake-up count must elapse before the bridges are allowed to drive.

Top module: `hbridge_supervisor`

## Requirements
- R1: While `uv_det` is 1, `logic_clr` is 1, `core_en` is 0, `drv_ready` is 0, every `brg_off` bit is 1 and `fault_n` is 1. Any latched overcurrent is cleared, and after release the bridges return to service once the wake delay has elapsed.
- R2: While `uv_det` is 0 and `reset_req_n` is 0, `logic_clr` is 1, `drv_ready` is 0, every bridge is off and `fault_n` is 1. Latched overcurrents are cleared and the current-limit and temperature flags are ignored.
- R3: While `sleep_req_n` is 0 (supply good), `core_en` is 0, `drv_ready` is 0 and every bridge is off. Current-limit flags are not timed and the temperature flag does not pull `fault_n` low.
- R4: `drv_ready` rises after exactly WAKE_CYCLES consecutive clock edges with `uv_det`=0, `reset_req_n`=1 and `sleep_req_n`=1. Any break in that condition drops it at once and restarts the count.
- R5: Bridge b owns flags `ilim_flag[b*SW_PER_BRIDGE +: SW_PER_BRIDGE]`. If any of them is sampled high on OC_CYCLES consecutive edges while `drv_ready` is 1, `brg_off[b]` goes to 1 after that edge and `fault_n` goes to 0. The other bridge is unaffected.
- R6: A current-limit burst shorter than OC_CYCLES edges leaves the bridge enabled and `fault_n` high, and a later burst starts timing from zero.
- R7: A latched overcurrent holds `brg_off[b]`=1 and `fault_n`=0 through a sleep period and after the flags clear, until R1 or R2 clears it.
- R8: While `ot_det` is 1 with reset and sleep requests high and supply good, every bridge is off and `fault_n` is 0 in the same cycle. Both release in the same cycle the flag falls.
- R9: With no latched overcurrent and no active overtemperature, `fault_n` is 1, and undervoltage never drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| reset_req_n | input | 1 | Active-low reset request |
| sleep_req_n | input | 1 | Active-low sleep request |
| uv_det | input | 1 | Supply below lockout threshold |
| ot_det | input | 1 | Die overtemperature |
| ilim_flag | input | NUM_BRIDGES*SW_PER_BRIDGE | Per-switch current-limit flags, grouped by bridge |
| brg_off | output | NUM_BRIDGES | Bridge disable, one per bridge |
| logic_clr | output | 1 | Clear for the driver's internal logic |
| core_en | output | 1 | Clock and charge-pump enable |
| fault_n | output | 1 | Active-low fault indication |
| drv_ready | output | 1 | Bridges allowed to drive |

## Verification
The assertions assume that undervoltage acts as the power-on clear. They take it to be high on the first clock edge so that the counters and latches start from a known state, and they are disabled while it or the reset request is active. They treat every input as synchronous to `clk`. The bench therefore starts with undervoltage high and changes every input a few nanoseconds after a rising edge. Its random phase gives current-limit flags bursts that straddle OC_CYCLES, keeps undervoltage, reset and sleep events rare so that the wake delay often completes, and holds overtemperature for short stretches.

// File: rtl/hbridge_supervisor.sv
`timescale 1ns/1ps
module hbridge_supervisor #(
  parameter int NUM_BRIDGES   = 2,
  parameter int SW_PER_BRIDGE = 4,
  parameter int OC_CYCLES     = 400,
  parameter int WAKE_CYCLES   = 100000
) (
  input  logic                                 clk,
  input  logic                                 reset_req_n,
  input  logic                                 sleep_req_n,
  input  logic                                 uv_det,
  input  logic                                 ot_det,
  input  logic [NUM_BRIDGES*SW_PER_BRIDGE-1:0] ilim_flag,
  output logic [NUM_BRIDGES-1:0]               brg_off,
  output logic                                 logic_clr,
  output logic                                 core_en,
  output logic                                 fault_n,
  output logic                                 drv_ready
);
  localparam int OCW = $clog2(OC_CYCLES + 1);
  localparam int WKW = $clog2(WAKE_CYCLES + 1);

  logic                   hold;
  logic                   awake;
  logic [WKW-1:0]         wake_cnt;
  logic [NUM_BRIDGES-1:0] oc_lat;

  assign hold      = uv_det | ~reset_req_n;
  assign logic_clr = hold;
  assign core_en   = ~uv_det & sleep_req_n;
  assign drv_ready = awake & ~hold & sleep_req_n;
  assign fault_n   = hold | ~(|oc_lat | (ot_det & sleep_req_n));

  always_ff @(posedge clk) begin
    if (hold || !sleep_req_n) begin
      wake_cnt <= '0;
      awake    <= 1'b0;
    end else if (!awake) begin
      wake_cnt <= wake_cnt + 1'b1;
      if (wake_cnt == WKW'(WAKE_CYCLES - 1)) awake <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    logic           any_ilim;
    logic [OCW-1:0] oc_cnt;

    assign any_ilim   = |ilim_flag[b*SW_PER_BRIDGE +: SW_PER_BRIDGE];
    assign brg_off[b] = ~drv_ready | oc_lat[b] | ot_det;

    always_ff @(posedge clk) begin
      if (hold) begin
        oc_cnt    <= '0;
        oc_lat[b] <= 1'b0;
      end else if (!drv_ready || !any_ilim) begin
        oc_cnt <= '0;
      end else if (oc_cnt == OCW'(OC_CYCLES - 1)) begin
        oc_lat[b] <= 1'b1;
      end else begin
        oc_cnt <= oc_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbridge_supervisor_chk.sv
`timescale 1ns/1ps
module hbridge_supervisor_chk #(
  parameter int NUM_BRIDGES = 2
) (
  input logic                   clk,
  input logic                   reset_req_n,
  input logic                   sleep_req_n,
  input logic                   uv_det,
  input logic                   ot_det,
  input logic [NUM_BRIDGES-1:0] brg_off,
  input logic                   logic_clr,
  input logic                   core_en,
  input logic                   fault_n,
  input logic                   drv_ready
);
  p_uv_lockout_r1: assert property (@(posedge clk) disable iff (!reset_req_n)
    uv_det |-> (logic_clr && !core_en && !drv_ready && fault_n && (&brg_off)));

  p_reset_hold_r2: assert property (@(posedge clk) disable iff (uv_det)
    !reset_req_n |-> (logic_clr && !drv_ready && fault_n && (&brg_off)));

  p_sleep_off_r3: assert property (@(posedge clk) disable iff (uv_det || !reset_req_n)
    !sleep_req_n |-> (!core_en && !drv_ready && (&brg_off)));

  p_wake_rise_r4: assert property (@(posedge clk) disable iff (uv_det || !reset_req_n)
    $rose(drv_ready) |-> $past(sleep_req_n));

  p_oc_sticky_r7: assert property (@(posedge clk) disable iff (uv_det || !reset_req_n)
    (!fault_n && !ot_det) |=> !fault_n);

  p_ot_shutdown_r8: assert property (@(posedge clk) disable iff (uv_det || !reset_req_n)
    (ot_det && sleep_req_n) |-> (!fault_n && (&brg_off)));
endmodule

bind hbridge_supervisor hbridge_supervisor_chk #(.NUM_BRIDGES(NUM_BRIDGES)) chk_i (
  .clk(clk), .reset_req_n(reset_req_n), .sleep_req_n(sleep_req_n),
  .uv_det(uv_det), .ot_det(ot_det), .brg_off(brg_off), .logic_clr(logic_clr),
  .core_en(core_en), .fault_n(fault_n), .drv_ready(drv_ready)
);

// File: tb/hbridge_supervisor_tb.sv
`timescale 1ns/1ps
module hbridge_supervisor_tb_top;
  localparam int NB   = 2;
  localparam int SW   = 4;
  localparam int OC   = 6;
  localparam int WAKE = 10;

  logic clk = 1'b0;
  logic reset_req_n, sleep_req_n, uv_det, ot_det;
  logic [NB*SW-1:0] ilim_flag;
  logic [NB-1:0] brg_off;
  logic logic_clr, core_en, fault_n, drv_ready;

  always #5 clk = ~clk;

  hbridge_supervisor #(.NUM_BRIDGES(NB), .SW_PER_BRIDGE(SW), .OC_CYCLES(OC),
                       .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .reset_req_n(reset_req_n), .sleep_req_n(sleep_req_n),
    .uv_det(uv_det), .ot_det(ot_det), .ilim_flag(ilim_flag), .brg_off(brg_off),
    .logic_clr(logic_clr), .core_en(core_en), .fault_n(fault_n), .drv_ready(drv_ready));

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  int m_wcnt = 0;
  bit m_awake = 1'b0;
  int m_cnt [NB];
  bit m_lat [NB];

  function automatic bit f_hold();
    return uv_det | ~reset_req_n;
  endfunction
  function automatic bit f_ready();
    return m_awake & ~f_hold() & sleep_req_n;
  endfunction
  function automatic bit f_fault_n();
    bit any = 1'b0;
    for (int b = 0; b < NB; b++) any |= m_lat[b];
    return f_hold() | ~(any | (ot_det & sleep_req_n));
  endfunction
  function automatic bit f_off(int b);
    return ~f_ready() | m_lat[b] | ot_det;
  endfunction

  always @(posedge clk) begin
    bit h, rdy;
    h   = f_hold();
    rdy = f_ready();
    if (h || !sleep_req_n) begin
      m_wcnt = 0; m_awake = 1'b0;
    end else if (!m_awake) begin
      m_wcnt++;
      if (m_wcnt == WAKE) m_awake = 1'b1;
    end
    for (int b = 0; b < NB; b++) begin
      if (h) begin
        m_cnt[b] = 0; m_lat[b] = 1'b0;
      end else if (!rdy || !(|ilim_flag[b*SW +: SW])) begin
        m_cnt[b] = 0;
      end else begin
        m_cnt[b]++;
        if (m_cnt[b] >= OC) m_lat[b] = 1'b1;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    chk("R2 logic_clr", logic_clr, f_hold());
    chk("R3 core_en", core_en, ~uv_det & sleep_req_n);
    chk("R4 drv_ready", drv_ready, f_ready());
    for (int b = 0; b < NB; b++) chk("R5 brg_off", brg_off[b], f_off(b));
    chk("R9 fault_n", fault_n, f_fault_n());
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wake_up();
    uv_det = 1'b0; reset_req_n = 1'b1; sleep_req_n = 1'b1;
    edges(WAKE);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int uv_left, rst_left, slp_left, ot_left;
    int burst [NB];
    for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_lat[b] = 1'b0; burst[b] = 0; end
    uv_det = 1'b1; reset_req_n = 1'b0; sleep_req_n = 1'b0; ot_det = 1'b0; ilim_flag = '0;
    edges(3);
    mon_en = 1'b1;
    chk("R1 reset state logic_clr", logic_clr, 1'b1);
    chk("R1 reset state brg_off", brg_off[0] & brg_off[1], 1'b1);
    chk("R1 reset state fault_n", fault_n, 1'b1);

    uv_det = 1'b0; reset_req_n = 1'b1; sleep_req_n = 1'b1;
    edges(WAKE - 1);
    chk("R4 not ready one edge early", drv_ready, 1'b0);
    edges(1);
    chk("R4 ready after wake delay", drv_ready, 1'b1);

    ilim_flag[1] = 1'b1;
    edges(OC - 1);
    ilim_flag = '0;
    edges(2);
    chk("R6 short burst bridge on", brg_off[0], 1'b0);
    chk("R6 short burst no fault", fault_n, 1'b1);

    ilim_flag[2] = 1'b1;
    edges(OC - 1);
    chk("R6 timer restarted", brg_off[0], 1'b0);
    edges(1);
    chk("R5 bridge0 latched", brg_off[0], 1'b1);
    chk("R5 bridge1 unaffected", brg_off[1], 1'b0);
    chk("R5 fault low", fault_n, 1'b0);
    ilim_flag = '0;
    edges(3);
    chk("R7 latch holds", brg_off[0], 1'b1);
    sleep_req_n = 1'b0;
    edges(2);
    wake_up();
    chk("R7 latch survives sleep", fault_n, 1'b0);
    chk("R7 bridge0 still off", brg_off[0], 1'b1);

    reset_req_n = 1'b0;
    edges(1);
    chk("R2 fault released in reset", fault_n, 1'b1);
    wake_up();
    chk("R2 latch cleared", brg_off[0], 1'b0);

    ot_det = 1'b1;
    #1;
    chk("R8 ot bridges off", brg_off[0] & brg_off[1], 1'b1);
    chk("R8 ot fault", fault_n, 1'b0);
    ot_det = 1'b0;
    #1;
    chk("R8 ot release", fault_n & ~brg_off[1], 1'b1);

    sleep_req_n = 1'b0; ot_det = 1'b1; ilim_flag = '1;
    edges(OC * 3);
    chk("R3 ot ignored asleep", fault_n, 1'b1);
    chk("R3 clocks off asleep", core_en, 1'b0);
    ot_det = 1'b0; ilim_flag = '0;
    wake_up();
    chk("R3 ilim ignored asleep", brg_off[0] | brg_off[1], 1'b0);

    ilim_flag[SW] = 1'b1;
    edges(OC);
    chk("R5 bridge1 latched", brg_off[1], 1'b1);
    ilim_flag = '0;
    uv_det = 1'b1;
    edges(1);
    chk("R1 uv no fault", fault_n, 1'b0 ^ 1'b1);
    chk("R1 uv clocks off", core_en, 1'b0);
    wake_up();
    chk("R1 uv cleared latch", brg_off[1], 1'b0);

    void'($urandom(32'h5eed_1234));
    uv_left = 0; rst_left = 0; slp_left = 0; ot_left = 0;
    for (int c = 0; c < 6000; c++) begin
      if (uv_left > 0) uv_left--; else if ($urandom % 400 == 0) uv_left = 1 + $urandom % 4;
      if (rst_left > 0) rst_left--; else if ($urandom % 300 == 0) rst_left = 1 + $urandom % 4;
      if (slp_left > 0) slp_left--; else if ($urandom % 200 == 0) slp_left = 1 + $urandom % 8;
      if (ot_left > 0) ot_left--; else if ($urandom % 60 == 0) ot_left = 1 + $urandom % 5;
      uv_det = (uv_left > 0); reset_req_n = (rst_left == 0);
      sleep_req_n = (slp_left == 0); ot_det = (ot_left > 0);
      for (int b = 0; b < NB; b++) begin
        if (burst[b] > 0) burst[b]--;
        else if ($urandom % 12 == 0) burst[b] = OC - 2 + $urandom % 4;
        ilim_flag[b*SW +: SW] = (burst[b] > 0) ? SW'((1 << ($urandom % SW))) : '0;
      end
      edges(1);
    end
    mon_en = 1'b0;
    finish_run();
  end
endmodule